// File: doc/BRIEF.md
# Floating-Point Status Register and Trap Controller

This block keeps the 17-bit status and mode word of a floating-point unit. Each floating-point instruction reports its completion with a one-cycle strobe and a vector of raw exception indications from the datapath. The block turns these indications into a single trap-type code, chosen by fixed priority. It keeps sticky flags for underflow and inexact results, and it decides whether the instruction must raise a trap. When an underflow is not enabled to trap, it also tells the datapath to replace the result with positive zero.

The load-status instruction writes the whole word through a load port. The store-status instruction reads it from a read port that always shows the current word. The block also drives the rounding-mode field for the arithmetic. A separate strobe marks writes to the floating-point data registers, and it sets a sticky bit that context-switch code can test. The block does not round results or detect exceptions; it only encodes, prioritises, records and signals them.

Top module: `fpstat_ctrl`

## Requirements
- R1: After a synchronous reset, the whole status word reads zero, `trap_o` and `ftz_o` are 0 and `rmode_o` is 00.
- R2: A load (`ld_i`) replaces the whole word with `ld_data_i`, visible on `rd_data_o` one cycle later. It takes precedence over a completion or a data-register write in the same cycle, but `trap_o`/`ftz_o` still follow the completing instruction.
- R3: Exception vector bits: 0 underflow, 1 overflow, 2 divide by zero, 3 illegal instruction, 4 invalid operation, 5 inexact. On completion, the trap type in bits 2:0 takes the highest-priority code: illegal 100, then invalid 101, then divide by zero 011, then overflow 010, then underflow 001, then inexact 110.
- R4: A completion with no exception writes trap type 000 and leaves the sticky flags unchanged.
- R5: The underflow flag (bit 4) is set on every completion that reports underflow, whatever the underflow enable (bit 3) holds. It stays set until reset or until a load writes 0 to it.
- R6: An inexact result is recorded (trap type 110, inexact flag bit 6 set) only when no other exception is reported in the same completion. Otherwise the inexact flag keeps its value.
- R7: Overflow, divide by zero, illegal instruction and invalid operation raise `trap_o` for one cycle, one cycle after the completion, whatever the enables hold.
- R8: An underflow raises `trap_o` only when the underflow enable is set. When the enable is clear, `ftz_o` pulses one cycle after the completion instead.
- R9: An inexact result raises `trap_o` only when the inexact enable (bit 5) is set and inexact is the only exception reported.
- R10: A data-register write strobe sets the register-modified bit (bit 16). It stays set until reset or until a load writes 0 to it.
- R11: The software field (bits 15:9) reads back whatever was loaded into it, and `rmode_o` always equals bits 8:7 (00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf).
- R12: Exception indications without a completion strobe have no effect: the word is unchanged and no trap or flush pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Completion strobe of a floating-point instruction (not load/store-status) |
| exc_i | input | 6 | Raw exception indications, bit order as in R3 |
| wr_fpreg_i | input | 1 | A floating-point data register is written this cycle |
| ld_i | input | 1 | Load-status write strobe |
| ld_data_i | input | 17 | Value written by the load-status instruction |
| rd_data_o | output | 17 | Current status word for the store-status instruction |
| rmode_o | output | 2 | Rounding-mode field |
| ftz_o | output | 1 | Replace the underflowed result with positive zero |
| trap_o | output | 1 | Trap request for the completing instruction |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This covers the new word on `rd_data_o`, the `rmode_o` field, and the single-cycle pulses on `trap_o` and `ftz_o`. The bench applies a strobe on a falling edge, lets one rising edge pass, removes the strobe and samples on the next falling edge. It therefore sees a pulse in the only cycle it is high, and it catches a stale or early value. Sticky-bit and idle checks sample again after further idle edges, to show that nothing decays or appears later.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
  // field positions inside the status word
  localparam int TT_W    = 3;
  localparam int TT_LSB  = 0;
  localparam int UEN_BIT = 3;
  localparam int UF_BIT  = 4;
  localparam int IEN_BIT = 5;
  localparam int IF_BIT  = 6;
  localparam int RM_LSB  = 7;
  localparam int RM_W    = 2;
  localparam int SWF_LSB = 9;

  // raw exception vector layout
  localparam int NEXC    = 6;
  localparam int EXC_UNF = 0;
  localparam int EXC_OVF = 1;
  localparam int EXC_DZ  = 2;
  localparam int EXC_ILL = 3;
  localparam int EXC_INV = 4;
  localparam int EXC_INX = 5;

  typedef enum logic [TT_W-1:0] {
    TT_NONE = 3'b000,
    TT_UNF  = 3'b001,
    TT_OVF  = 3'b010,
    TT_DZ   = 3'b011,
    TT_ILL  = 3'b100,
    TT_INV  = 3'b101,
    TT_INX  = 3'b110
  } tt_code_e;
endpackage

// File: rtl/fpstat_prio.sv
module fpstat_prio
  import fpstat_pkg::*;
(
  input  logic [NEXC-1:0] exc_i,
  output tt_code_e        tt_o,
  output logic            hard_o,
  output logic            inx_alone_o
);
  logic any_other;

  always_comb begin
    hard_o      = exc_i[EXC_OVF] | exc_i[EXC_DZ] | exc_i[EXC_ILL] | exc_i[EXC_INV];
    any_other   = hard_o | exc_i[EXC_UNF];
    inx_alone_o = exc_i[EXC_INX] & ~any_other;
    if (exc_i[EXC_ILL])      tt_o = TT_ILL;
    else if (exc_i[EXC_INV]) tt_o = TT_INV;
    else if (exc_i[EXC_DZ])  tt_o = TT_DZ;
    else if (exc_i[EXC_OVF]) tt_o = TT_OVF;
    else if (exc_i[EXC_UNF]) tt_o = TT_UNF;
    else if (exc_i[EXC_INX]) tt_o = TT_INX;
    else                     tt_o = TT_NONE;
  end
endmodule

// File: rtl/fpstat_trap.sv
module fpstat_trap
  import fpstat_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            done_i,
  input  logic [NEXC-1:0] exc_i,
  input  logic            hard_i,
  input  logic            inx_alone_i,
  input  logic            uen_i,
  input  logic            ien_i,
  output logic            trap_o,
  output logic            ftz_o
);
  logic trap_d;
  logic ftz_d;

  always_comb begin
    trap_d = done_i & (hard_i | (exc_i[EXC_UNF] & uen_i) | (inx_alone_i & ien_i));
    ftz_d  = done_i & exc_i[EXC_UNF] & ~uen_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o <= 1'b0;
      ftz_o  <= 1'b0;
    end else begin
      trap_o <= trap_d;
      ftz_o  <= ftz_d;
    end
  end
endmodule

// File: rtl/fpstat_regs.sv
module fpstat_regs
  import fpstat_pkg::*;
#(
  parameter int REG_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_i,
  input  logic [REG_W-1:0] ld_data_i,
  input  logic             done_i,
  input  tt_code_e         tt_i,
  input  logic             set_uf_i,
  input  logic             set_if_i,
  input  logic             wr_fpreg_i,
  output logic [REG_W-1:0] word_o
);
  localparam int RMB_BIT = REG_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
    end else if (ld_i) begin
      word_o <= ld_data_i;
    end else begin
      if (done_i) begin
        word_o[TT_LSB +: TT_W] <= tt_i;
        if (set_uf_i) word_o[UF_BIT] <= 1'b1;
        if (set_if_i) word_o[IF_BIT] <= 1'b1;
      end
      if (wr_fpreg_i) word_o[RMB_BIT] <= 1'b1;
    end
  end
endmodule

// File: rtl/fpstat_ctrl.sv
module fpstat_ctrl
  import fpstat_pkg::*;
#(
  parameter  int SWF_W = 7,
  localparam int REG_W = SWF_LSB + SWF_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_i,
  input  logic [NEXC-1:0]  exc_i,
  input  logic             wr_fpreg_i,
  input  logic             ld_i,
  input  logic [REG_W-1:0] ld_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [RM_W-1:0]  rmode_o,
  output logic             ftz_o,
  output logic             trap_o
);
  tt_code_e tt_sel;
  logic     hard;
  logic     inx_alone;

  fpstat_prio u_prio (
    .exc_i       (exc_i),
    .tt_o        (tt_sel),
    .hard_o      (hard),
    .inx_alone_o (inx_alone)
  );

  fpstat_regs #(.REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .ld_i       (ld_i),
    .ld_data_i  (ld_data_i),
    .done_i     (done_i),
    .tt_i       (tt_sel),
    .set_uf_i   (exc_i[EXC_UNF]),
    .set_if_i   (inx_alone),
    .wr_fpreg_i (wr_fpreg_i),
    .word_o     (rd_data_o)
  );

  fpstat_trap u_trap (
    .clk         (clk),
    .rst         (rst),
    .done_i      (done_i),
    .exc_i       (exc_i),
    .hard_i      (hard),
    .inx_alone_i (inx_alone),
    .uen_i       (rd_data_o[UEN_BIT]),
    .ien_i       (rd_data_o[IEN_BIT]),
    .trap_o      (trap_o),
    .ftz_o       (ftz_o)
  );

  assign rmode_o = rd_data_o[RM_LSB +: RM_W];
endmodule

// File: rtl/fpstat_ctrl_chk.sv
module fpstat_ctrl_chk
  import fpstat_pkg::*;
#(
  parameter int REG_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             done_i,
  input logic [NEXC-1:0]  exc_i,
  input logic             wr_fpreg_i,
  input logic             ld_i,
  input logic [REG_W-1:0] ld_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             ftz_o,
  input logic             trap_o
);
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst) ld_i |=> rd_data_o == $past(ld_data_i)); // R2
  AST_CLEAN_CLEARS_TT: assert property (@(posedge clk) disable iff (rst) (done_i && !ld_i && exc_i == '0) |=> rd_data_o[TT_W-1:0] == 3'b000); // R4
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (rst) (!ld_i && rd_data_o[UF_BIT]) |=> rd_data_o[UF_BIT]); // R5
  AST_HARD_TRAP: assert property (@(posedge clk) disable iff (rst) (done_i && (exc_i[EXC_OVF] || exc_i[EXC_DZ] || exc_i[EXC_ILL] || exc_i[EXC_INV])) |=> trap_o); // R7
  AST_UNF_FLUSH: assert property (@(posedge clk) disable iff (rst) (done_i && exc_i[EXC_UNF] && !rd_data_o[UEN_BIT]) |=> ftz_o); // R8
  AST_RMB_STICKY: assert property (@(posedge clk) disable iff (rst) (!ld_i && rd_data_o[REG_W-1]) |=> rd_data_o[REG_W-1]); // R10
  AST_TRAP_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst) (trap_o || ftz_o) |-> $past(done_i)); // R12
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst) (!done_i && !ld_i && !wr_fpreg_i) |=> $stable(rd_data_o)); // R12
endmodule

bind fpstat_ctrl fpstat_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .done_i     (done_i),
  .exc_i      (exc_i),
  .wr_fpreg_i (wr_fpreg_i),
  .ld_i       (ld_i),
  .ld_data_i  (ld_data_i),
  .rd_data_o  (rd_data_o),
  .ftz_o      (ftz_o),
  .trap_o     (trap_o)
);

// File: tb/fpstat_ctrl_bench.sv
module fpstat_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        done_i;
  logic [5:0]  exc_i;
  logic        wr_fpreg_i;
  logic        ld_i;
  logic [16:0] ld_data_i;
  logic [16:0] rd_data_o;
  logic [1:0]  rmode_o;
  logic        ftz_o;
  logic        trap_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fpstat_ctrl u_fpstat_ctrl (
    .clk(clk), .rst(rst), .done_i(done_i), .exc_i(exc_i),
    .wr_fpreg_i(wr_fpreg_i), .ld_i(ld_i), .ld_data_i(ld_data_i),
    .rd_data_o(rd_data_o), .rmode_o(rmode_o), .ftz_o(ftz_o), .trap_o(trap_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one strobe cycle from a falling edge, sample at the next falling edge
  task automatic op(input logic dn, input logic [5:0] ex, input logic wr,
                    input logic ld, input logic [16:0] ldv);
    done_i = dn; exc_i = ex; wr_fpreg_i = wr; ld_i = ld; ld_data_i = ldv;
    @(negedge clk);
    done_i = 1'b0; exc_i = '0; wr_fpreg_i = 1'b0; ld_i = 1'b0; ld_data_i = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 word", {15'd0, rd_data_o}, 32'd0);
    chk("R1 trap", {31'd0, trap_o}, 32'd0);
    chk("R1 ftz", {31'd0, ftz_o}, 32'd0);
    chk("R1 rmode", {30'd0, rmode_o}, 32'd0);
  endtask

  task automatic t_load_swf;
    op(0, 0, 0, 1, 17'h0_AB80); // swf=0x55, rmode=11
    chk("R2 load", {15'd0, rd_data_o}, 32'h0_AB80);
    chk("R11 rmode", {30'd0, rmode_o}, 32'd3);
    op(1, 0, 1, 0, 0);
    idle(2);
    chk("R11 swf kept", {25'd0, rd_data_o[15:9]}, 32'h55);
    op(0, 0, 0, 1, 17'h0_0100); // rmode=10
    chk("R11 rmode 10", {30'd0, rmode_o}, 32'd2);
  endtask

  task automatic t_priority;
    op(0, 0, 0, 1, 17'h0_0000);
    op(1, 6'b011111, 0, 0, 0);
    chk("R3 illegal first", {29'd0, rd_data_o[2:0]}, 32'd4);
    chk("R7 trap illegal", {31'd0, trap_o}, 32'd1);
    op(1, 6'b010111, 0, 0, 0);
    chk("R3 invalid next", {29'd0, rd_data_o[2:0]}, 32'd5);
    op(1, 6'b000111, 0, 0, 0);
    chk("R3 divzero next", {29'd0, rd_data_o[2:0]}, 32'd3);
    op(1, 6'b000011, 0, 0, 0);
    chk("R3 overflow next", {29'd0, rd_data_o[2:0]}, 32'd2);
    chk("R7 trap overflow", {31'd0, trap_o}, 32'd1);
    idle(1);
    chk("R7 trap one cycle", {31'd0, trap_o}, 32'd0);
  endtask

  task automatic t_clean;
    op(0, 0, 0, 1, 17'h0_0050); // UF and IF set, TT 000
    op(1, 6'b000100, 0, 0, 0);
    chk("R4 tt set", {29'd0, rd_data_o[2:0]}, 32'd3);
    op(1, 0, 0, 0, 0);
    chk("R4 clean tt", {29'd0, rd_data_o[2:0]}, 32'd0);
    chk("R4 flags kept", {30'd0, rd_data_o[6], rd_data_o[4]}, 32'd3);
    chk("R4 no trap", {31'd0, trap_o}, 32'd0);
  endtask

  task automatic t_underflow;
    op(0, 0, 0, 1, 17'h0_0000);
    op(1, 6'b000001, 0, 0, 0);
    chk("R5 uf set uen0", {31'd0, rd_data_o[4]}, 32'd1);
    chk("R3 tt underflow", {29'd0, rd_data_o[2:0]}, 32'd1);
    chk("R8 ftz uen0", {31'd0, ftz_o}, 32'd1);
    chk("R8 no trap uen0", {31'd0, trap_o}, 32'd0);
    op(1, 0, 0, 0, 0);
    idle(2);
    chk("R5 uf sticky", {31'd0, rd_data_o[4]}, 32'd1);
    op(0, 0, 0, 1, 17'h0_0008); // uen=1, uf cleared
    chk("R5 uf cleared by load", {31'd0, rd_data_o[4]}, 32'd0);
    op(1, 6'b000001, 0, 0, 0);
    chk("R8 trap uen1", {31'd0, trap_o}, 32'd1);
    chk("R8 no ftz uen1", {31'd0, ftz_o}, 32'd0);
    chk("R5 uf set uen1", {31'd0, rd_data_o[4]}, 32'd1);
  endtask

  task automatic t_inexact;
    op(0, 0, 0, 1, 17'h0_0000);
    op(1, 6'b100000, 0, 0, 0);
    chk("R6 tt inexact", {29'd0, rd_data_o[2:0]}, 32'd6);
    chk("R6 if set", {31'd0, rd_data_o[6]}, 32'd1);
    chk("R9 no trap ien0", {31'd0, trap_o}, 32'd0);
    op(0, 0, 0, 1, 17'h0_0020); // ien=1, if=0
    op(1, 6'b100010, 0, 0, 0);
    chk("R6 tt other wins", {29'd0, rd_data_o[2:0]}, 32'd2);
    chk("R6 if unchanged", {31'd0, rd_data_o[6]}, 32'd0);
    op(1, 6'b100001, 0, 0, 0); // uen=0: underflow suppresses inexact trap
    chk("R9 no trap with unf", {31'd0, trap_o}, 32'd0);
    chk("R8 ftz with inexact", {31'd0, ftz_o}, 32'd1);
    chk("R6 if still clear", {31'd0, rd_data_o[6]}, 32'd0);
    op(1, 6'b100000, 0, 0, 0);
    chk("R9 trap ien1", {31'd0, trap_o}, 32'd1);
  endtask

  task automatic t_rmb;
    op(0, 0, 0, 1, 17'h0_0000);
    op(0, 0, 1, 0, 0);
    chk("R10 rmb set", {31'd0, rd_data_o[16]}, 32'd1);
    op(1, 0, 0, 0, 0);
    idle(2);
    chk("R10 rmb sticky", {31'd0, rd_data_o[16]}, 32'd1);
    op(0, 0, 0, 1, 17'h0_0000);
    chk("R10 rmb cleared", {31'd0, rd_data_o[16]}, 32'd0);
  endtask

  task automatic t_ignore;
    op(0, 0, 0, 1, 17'h0_0182);
    op(0, 6'b111111, 0, 0, 0);
    chk("R12 no trap", {31'd0, trap_o}, 32'd0);
    chk("R12 no ftz", {31'd0, ftz_o}, 32'd0);
    chk("R12 word kept", {15'd0, rd_data_o}, 32'h0_0182);
  endtask

  task automatic t_precedence;
    op(0, 0, 0, 1, 17'h0_0000);
    op(1, 6'b000011, 1, 1, 17'h0_1205);
    chk("R2 load beats done", {15'd0, rd_data_o}, 32'h0_1205);
    chk("R2 trap still raised", {31'd0, trap_o}, 32'd1);
  endtask

  initial begin
    rst = 1'b1; done_i = 0; exc_i = 0; wr_fpreg_i = 0; ld_i = 0; ld_data_i = 0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_swf();
    t_priority();
    t_clean();
    t_underflow();
    t_inexact();
    t_rmb();
    t_ignore();
    t_precedence();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule